// File: doc/BRIEF.md
# Receive Interrupt Watchdog Timer

This block defers the receive interrupt so that several received frames can share one interrupt. The receive DMA reports each frame it has finished writing to memory, together with a flag. The flag is high when that frame's descriptor asked for an interrupt at once. A frame that asked for no interrupt starts a countdown. The countdown length comes from an 8-bit timeout field set by software. When the countdown runs out, the block emits a one-cycle set pulse for the receive-interrupt status bit. The status register and its enable gating are outside this block.

The countdown advances only on a prescaler tick supplied from outside, so the delay is the programmed value times the tick period. The first waiting frame fixes the deadline, and later silent frames do not push it back. A frame that asks for an immediate interrupt produces the set pulse directly and stops any countdown in progress. A timeout of zero turns the watchdog off.

Top module: `rx_irq_watchdog`

## Requirements
- R1: After reset, rx_set_o is low and the timer is idle, so ticks alone produce no pulse.
- R2: With timeout_i equal to zero, a frame completion with desc_irq_i low never causes a pulse.
- R3: With timeout_i = N > 0, a frame completion with desc_irq_i low arms the timer. rx_set_o is high for exactly one cycle, in the cycle after the N-th tick_i sampled after the arming cycle.
- R4: A tick_i in the same cycle as the arming frame completion is not counted.
- R5: Further frame completions with desc_irq_i low while the timer runs do not restart or delay the countdown.
- R6: A frame completion with desc_irq_i high drives rx_set_o high in the next cycle and cancels a running countdown, so no later expiry pulse follows.
- R7: A frame completion with desc_irq_i high while the timer is idle also pulses rx_set_o in the next cycle, for one cycle.
- R8: A change of timeout_i while the timer runs does not alter the countdown in progress. The new value is used at the next arming.
- R9: After expiry the timer is idle, and further ticks cause no pulse until a new arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| timeout_i | input | 8 | Timeout in prescaler ticks, zero disables the timer |
| tick_i | input | 1 | Prescaler tick, one-cycle strobe |
| frame_done_i | input | 1 | One-cycle strobe for a frame fully written to memory |
| desc_irq_i | input | 1 | Descriptor of the completed frame requests an immediate interrupt |
| rx_set_o | output | 1 | One-cycle pulse setting the receive-interrupt status bit |

## Verification
Each result is registered once. A pulse from an immediate-request frame appears in the cycle after that frame is sampled. An expiry pulse appears in the cycle after the edge that samples the N-th counted tick. The bench drives each cycle's inputs on the falling edge and reads rx_set_o on the next falling edge, so every read shows the response to exactly that cycle's inputs. The checks therefore name the exact cycle in which a pulse is due, and they also check the cycles before and after it where the output must stay low.

// File: rtl/rx_irq_watchdog_pkg.sv
package rx_irq_watchdog_pkg;
  typedef enum logic {
    WDT_IDLE = 1'b0,
    WDT_RUN  = 1'b1
  } wdt_state_e;
endpackage

// File: rtl/rx_irq_wdt_counter.sv
module rx_irq_wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= value_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == ONE);

  // R3
  dec_from_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/rx_irq_wdt_ctrl.sv
module rx_irq_wdt_ctrl
  import rx_irq_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic             tick_i,
  input  logic             frame_done_i,
  input  logic             desc_irq_i,
  input  logic             last_i,
  output logic             load_o,
  output logic             dec_o,
  output logic             set_o,
  output wdt_state_e       state_o
);
  wdt_state_e state_q, state_d;
  logic       set_q, set_d;
  logic       fire_now, expire, arm;

  assign fire_now = frame_done_i && desc_irq_i;
  assign expire   = (state_q == WDT_RUN) && tick_i && last_i;
  assign arm      = (state_q == WDT_IDLE) && frame_done_i && !desc_irq_i
                    && (timeout_i != '0);

  always_comb begin
    state_d = state_q;
    set_d   = 1'b0;
    if (fire_now) begin
      state_d = WDT_IDLE;
      set_d   = 1'b1;
    end else if (expire) begin
      state_d = WDT_IDLE;
      set_d   = 1'b1;
    end else if (arm) begin
      state_d = WDT_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WDT_IDLE;
      set_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      set_q   <= set_d;
    end
  end

  assign load_o  = arm && !fire_now;
  assign dec_o   = (state_q == WDT_RUN) && tick_i && !fire_now;
  assign set_o   = set_q;
  assign state_o = state_q;

  // R2
  zero_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WDT_IDLE && timeout_i == '0 && !desc_irq_i) |=> (state_q == WDT_IDLE));

  // R6
  cancel_on_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && desc_irq_i) |=> (set_q && state_q == WDT_IDLE));

  // R9
  expiry_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_q == WDT_RUN) |-> set_q);
endmodule

// File: rtl/rx_irq_watchdog.sv
module rx_irq_watchdog
  import rx_irq_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic             tick_i,
  input  logic             frame_done_i,
  input  logic             desc_irq_i,
  output logic             rx_set_o
);
  logic             load, dec, last;
  logic [CNT_W-1:0] cnt;
  wdt_state_e       state;

  rx_irq_wdt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .timeout_i    (timeout_i),
    .tick_i       (tick_i),
    .frame_done_i (frame_done_i),
    .desc_irq_i   (desc_irq_i),
    .last_i       (last),
    .load_o       (load),
    .dec_o        (dec),
    .set_o        (rx_set_o),
    .state_o      (state)
  );

  rx_irq_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .value_i (timeout_i),
    .dec_i   (dec),
    .cnt_o   (cnt),
    .last_o  (last)
  );

  // R5
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == WDT_RUN && frame_done_i && !desc_irq_i && !tick_i) |=> $stable(cnt));

  // R8
  no_retarget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == WDT_RUN && !tick_i && !frame_done_i) |=> $stable(cnt));

  // R3
  pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_set_o |-> ($past(frame_done_i && desc_irq_i) || $past(state == WDT_RUN && tick_i)));
endmodule

// File: tb/rx_irq_watchdog_bench.sv
module rx_irq_watchdog_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] timeout_i = '0;
  logic       tick_i = 1'b0;
  logic       frame_done_i = 1'b0;
  logic       desc_irq_i = 1'b0;
  logic       rx_set_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rx_irq_watchdog u_rx_irq_watchdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .timeout_i(timeout_i), .tick_i(tick_i),
    .frame_done_i(frame_done_i), .desc_irq_i(desc_irq_i), .rx_set_o(rx_set_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rx_set_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at falling edge, read response on the next falling edge
  task automatic cyc(input logic fd, input logic irq, input logic tk, output logic o);
    frame_done_i = fd;
    desc_irq_i   = irq;
    tick_i       = tk;
    @(negedge clk_i);
    o = rx_set_o;
    frame_done_i = 1'b0;
    desc_irq_i   = 1'b0;
    tick_i       = 1'b0;
  endtask

  task automatic idle_n(input int n, input string req);
    logic o;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0, 1'b1, o);
      check(o, 1'b0, req);
    end
  endtask

  task automatic t_reset;
    logic o;
    check(rx_set_o, 1'b0, "R1");
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, 1'b1, o);
      check(o, 1'b0, "R1");
    end
  endtask

  task automatic t_zero;
    logic o;
    timeout_i = 8'd0;
    cyc(1'b1, 1'b0, 1'b0, o);
    check(o, 1'b0, "R2");
    idle_n(20, "R2");
  endtask

  task automatic t_basic(input int n);
    logic o;
    timeout_i = 8'(n);
    cyc(1'b1, 1'b0, 1'b0, o);
    check(o, 1'b0, "R3");
    for (int i = 1; i <= n; i++) begin
      cyc(1'b0, 1'b0, 1'b0, o);
      check(o, 1'b0, "R3");
      cyc(1'b0, 1'b0, 1'b1, o);
      check(o, (i == n), "R3");
    end
    cyc(1'b0, 1'b0, 1'b0, o);
    check(o, 1'b0, "R3");
    idle_n(n + 3, "R9");
  endtask

  task automatic t_arm_tick;
    logic o;
    timeout_i = 8'd2;
    cyc(1'b1, 1'b0, 1'b1, o);
    check(o, 1'b0, "R4");
    cyc(1'b0, 1'b0, 1'b1, o);
    check(o, 1'b0, "R4");
    cyc(1'b0, 1'b0, 1'b1, o);
    check(o, 1'b1, "R4");
    cyc(1'b0, 1'b0, 1'b0, o);
    check(o, 1'b0, "R4");
  endtask

  task automatic t_no_restart;
    logic o;
    timeout_i = 8'd3;
    cyc(1'b1, 1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, 1'b1, o);
    check(o, 1'b0, "R5");
    cyc(1'b1, 1'b0, 1'b0, o);
    check(o, 1'b0, "R5");
    cyc(1'b0, 1'b0, 1'b1, o);
    check(o, 1'b0, "R5");
    cyc(1'b1, 1'b0, 1'b1, o);
    check(o, 1'b1, "R5");
    idle_n(5, "R5");
  endtask

  task automatic t_cancel;
    logic o;
    timeout_i = 8'd4;
    cyc(1'b1, 1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, 1'b1, o);
    cyc(1'b1, 1'b1, 1'b0, o);
    check(o, 1'b1, "R6");
    cyc(1'b0, 1'b0, 1'b0, o);
    check(o, 1'b0, "R6");
    idle_n(8, "R6");
  endtask

  task automatic t_idle_irq;
    logic o;
    cyc(1'b1, 1'b1, 1'b0, o);
    check(o, 1'b1, "R7");
    cyc(1'b0, 1'b0, 1'b0, o);
    check(o, 1'b0, "R7");
  endtask

  task automatic t_reload;
    logic o;
    timeout_i = 8'd2;
    cyc(1'b1, 1'b0, 1'b0, o);
    timeout_i = 8'd6;
    cyc(1'b0, 1'b0, 1'b1, o);
    check(o, 1'b0, "R8");
    cyc(1'b0, 1'b0, 1'b1, o);
    check(o, 1'b1, "R8");
    cyc(1'b1, 1'b0, 1'b0, o);
    for (int i = 1; i <= 6; i++) begin
      cyc(1'b0, 1'b0, 1'b1, o);
      check(o, (i == 6), "R8");
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_zero();
    t_basic(1);
    t_basic(5);
    t_basic(255);
    t_arm_tick();
    t_no_restart();
    t_cancel();
    t_idle_irq();
    t_reload();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule